// File: doc/BRIEF.md
# Return-Context Stack Engine

This block saves and restores a subroutine or interrupt return context in a small window of an internal byte-wide data RAM. The window starts at address 0x08 and holds eight two-byte frames. A 3-bit frame pointer lives in the low bits of the 8-bit status word. A push packs the 12-bit program counter and the four upper status flags into one frame. A return brings the program counter back. A return-from-interrupt brings back both the program counter and the saved flags.

The sequencer of the core issues a one-cycle strobe: push, plain return or interrupt return. It presents the current program counter and status word with that strobe. The block then drives the RAM address, write data and write enable. The RAM is synchronous: read data appears the cycle after the address. When the operation is complete, the block raises `done` for one cycle. The restored program counter and the updated status word are held on the outputs until the next operation.

Top module: `ctx_stack`

## Requirements
- R1: After reset, `done` and `ram_we` are 0, `pc_out` is 0x000 and `psw_out` is 0x08.
- R2: In the first write cycle of a push, the block writes PC bits 7..0 to address 8+2·sp, where sp is `psw_in[2:0]`.
- R3: In the next cycle, a push writes address 9+2·sp with status bits 7..4 in bits 7..4 and PC bits 11..8 in bits 3..0. The two writes are the only writes of the push, and they fall in consecutive cycles.
- R4: `done` is high for exactly one cycle. It rises 3 clock cycles after the cycle in which a push strobe is sampled. After a push, `psw_out` holds `psw_in[7:4]` unchanged in bits 7..4 and sp+1 mod 8 in bits 2..0, and `pc_out` equals `pc_in`.
- R5: A plain return first decrements the pointer (s = sp−1 mod 8). It then reads addresses 8+2·s and 9+2·s, and `done` rises 4 cycles after the strobe. `pc_out` is {byte(9+2s)[3:0], byte(8+2s)}, and `psw_out` bits 7..4 equal `psw_in[7:4]`.
- R6: A return-from-interrupt behaves as R5, except that `psw_out` bits 7..4 are taken from byte(9+2s)[7:4].
- R7: The pointer wraps. A push at sp=7 uses addresses 0x16/0x17 and leaves the pointer at 0. A return at sp=0 reads 0x16/0x17 and leaves the pointer at 7. Every write falls in 0x08..0x17.
- R8: `psw_out` bit 3 always reads 1, whatever `psw_in[3]` is.
- R9: Returns never write the RAM. A ninth push in a row silently overwrites frame 0, with no error indication.
- R10: Strobes that arrive while an operation is in progress are ignored. They cause no write, and they do not change the result.
- R11: When strobes coincide, push takes precedence over return-from-interrupt, and return-from-interrupt takes precedence over plain return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Save-context strobe |
| ret_req | input | 1 | Plain-return strobe |
| reti_req | input | 1 | Interrupt-return strobe |
| pc_in | input | 12 | Program counter to save |
| psw_in | input | 8 | Current status word (flags 7..4, pointer 2..0) |
| ram_rdata | input | 8 | RAM read data, one cycle after address |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| pc_out | output | 12 | Restored program counter |
| psw_out | output | 8 | Updated status word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random sequences of pushes, plain returns and interrupt returns are driven with random PC values, random flags and random values of the unused bit 3. They are checked against a bench model of the frame layout and the pointer arithmetic. Because the flags in the status word differ from the saved flags, these runs separate the two return types. Directed cases cover the following: pointer wrap in both directions, which shows that modulo-8 arithmetic is used rather than saturation; a ninth push overwriting frame 0; strobes arriving during an operation, which shows that they are ignored; and coincident strobes, which shows the precedence order.

// File: rtl/ctx_stack_pkg.sv
// Package: shared types and fixed field widths of the return-context stack.
// Assumes an 8-bit status word with the pointer in bits 2..0 and flags in 7..4.
package ctx_stack_pkg;
    localparam int PSW_W  = 8;
    localparam int FLAG_W = 4;
    localparam int SP_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_WAIT,
        ST_FIN
    } stk_state_t;
endpackage

// File: rtl/stk_frame_addr.sv
// Module: maps a frame pointer and a byte select onto a RAM address.
// Assumes frames are two bytes wide and packed upward from BASE.
module stk_frame_addr #(
    parameter int ADDR_W = 8,
    parameter int SP_W   = 3,
    parameter int BASE   = 8
) (
    input  logic [SP_W-1:0]   ptr,
    input  logic              hi_byte,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    // Frame address: base plus twice the pointer plus the byte select.
    always_comb begin
        addr = BASE_A + ADDR_W'({ptr, 1'b0}) + ADDR_W'(hi_byte);
    end
endmodule

// File: rtl/stk_seq.sv
// Module: operation sequencer. It accepts a strobe only when idle, with the
// precedence push > interrupt return > plain return.
// Assumes strobes last one cycle; strobes seen outside idle are dropped.
module stk_seq
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  logic       ret_req,
    input  logic       reti_req,
    output stk_state_t st,
    output logic       reti_q
);
    stk_state_t nxt;

    // Next state: push takes two write cycles, pop takes three read cycles.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (push_req)                nxt = ST_PUSH_LO;
                else if (reti_req || ret_req) nxt = ST_POP_LO;
            end
            ST_PUSH_LO:  nxt = ST_PUSH_HI;
            ST_PUSH_HI:  nxt = ST_FIN;
            ST_POP_LO:   nxt = ST_POP_HI;
            ST_POP_HI:   nxt = ST_POP_WAIT;
            ST_POP_WAIT: nxt = ST_FIN;
            ST_FIN:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register and the latched return type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            reti_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && !push_req)
                reti_q <= reti_req;
        end
    end

    AST_IDLE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIN) |=> (st == ST_IDLE)) else $error("fin not single");  // R4
endmodule

// File: rtl/ctx_stack.sv
// Module: return-context stack engine. It saves and restores the PC and the
// status flags in two-byte frames of an external synchronous RAM.
// Assumes the RAM returns read data one cycle after the address and that the
// caller holds pc_in and psw_in valid in the strobe cycle only.
module ctx_stack
    import ctx_stack_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int ADDR_W     = 8,
    parameter int STACK_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              ret_req,
    input  logic              reti_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PSW_W-1:0]  psw_in,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    output logic [PC_W-1:0]   pc_out,
    output logic [PSW_W-1:0]  psw_out,
    output logic              done
);
    localparam int PCH_W = PC_W - 8;
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(STACK_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(STACK_BASE + 2 * (1 << SP_W) - 1);

    stk_state_t        st;
    logic              reti_q;
    logic [PC_W-1:0]   pc_q;
    logic [FLAG_W-1:0] flags_q;
    logic [SP_W-1:0]   sp_q;
    logic              hi_sel;
    logic              unused_psw_bit3;

    assign unused_psw_bit3 = psw_in[3];

    stk_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .ret_req  (ret_req),
        .reti_req (reti_req),
        .st       (st),
        .reti_q   (reti_q)
    );

    stk_frame_addr #(
        .ADDR_W (ADDR_W),
        .SP_W   (SP_W),
        .BASE   (STACK_BASE)
    ) u_addr (
        .ptr     (sp_q),
        .hi_byte (hi_sel),
        .addr    (ram_addr)
    );

    // RAM control: select the byte of the frame and drive the write data.
    always_comb begin
        hi_sel    = (st == ST_PUSH_HI) || (st == ST_POP_HI);
        ram_we    = (st == ST_PUSH_LO) || (st == ST_PUSH_HI);
        ram_wdata = (st == ST_PUSH_HI) ? {flags_q, pc_q[PC_W-1:8]} : pc_q[7:0];
    end

    // Context registers: capture on the strobe, update the pointer, load read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
            sp_q    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (push_req) begin
                        pc_q    <= pc_in;
                        flags_q <= psw_in[PSW_W-1 -: FLAG_W];
                        sp_q    <= psw_in[SP_W-1:0];
                    end else if (reti_req || ret_req) begin
                        flags_q <= psw_in[PSW_W-1 -: FLAG_W];
                        sp_q    <= psw_in[SP_W-1:0] - 1'b1;
                    end
                end
                ST_PUSH_HI: sp_q <= sp_q + 1'b1;
                ST_POP_HI:  pc_q[7:0] <= ram_rdata;
                ST_POP_WAIT: begin
                    pc_q[PC_W-1:8] <= ram_rdata[PCH_W-1:0];
                    if (reti_q)
                        flags_q <= ram_rdata[7 -: FLAG_W];
                end
                default: ;
            endcase
        end
    end

    // Outputs: the fixed bit 3 is inserted between the flags and the pointer.
    always_comb begin
        pc_out  = pc_q;
        psw_out = {flags_q, 1'b1, sp_q};
        done    = (st == ST_FIN);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");  // R4
    AST_WE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !$past(ram_we)) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1))
        else $error("frame writes not paired");  // R3
    AST_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr >= WIN_LO && ram_addr <= WIN_HI))
        else $error("write outside window");  // R7
    AST_BIT3_SET: assert property (@(posedge clk) disable iff (!rst_n)
        psw_out[3]) else $error("status bit 3 low");  // R8
    AST_NO_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we) else $error("write at completion");  // R9
endmodule

// File: tb/ctx_stack_test.sv
module ctx_stack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, ret_req = 1'b0, reti_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic [7:0]  psw_in = '0;
    logic [7:0]  ram_rdata;
    logic [7:0]  ram_addr, ram_wdata;
    logic        ram_we;
    logic [11:0] pc_out;
    logic [7:0]  psw_out;
    logic        done;

    logic [7:0]  mem [256];
    int          wr_cnt = 0;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_stack uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .ret_req(ret_req),
        .reti_req(reti_req), .pc_in(pc_in), .psw_in(psw_in), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .pc_out(pc_out), .psw_out(psw_out), .done(done)
    );

    // Synchronous RAM model, preloaded during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_push_psw(input logic [7:0] p);
        return {p[7:4], 1'b1, 3'(p[2:0] + 3'd1)};
    endfunction

    function automatic logic [7:0] fr_addr(input logic [2:0] s, input bit hi);
        return 8'(8 + 2 * s + (hi ? 1 : 0));
    endfunction

    // Drive one operation; return the latency in cycles and the number of writes.
    task automatic run_op(input bit p, input bit r, input bit ri, input logic [11:0] pc,
                          input logic [7:0] psw, input bit disturb, output int lat, output int wrs);
        int w0;
        @(negedge clk);
        push_req = p; ret_req = r; reti_req = ri; pc_in = pc; psw_in = psw;
        w0 = wr_cnt;
        @(negedge clk);
        push_req = disturb; ret_req = disturb; reti_req = disturb;
        pc_in = ~pc; psw_in = ~psw;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            push_req = 1'b0; ret_req = 1'b0; reti_req = 1'b0;
            lat++;
        end
        push_req = 1'b0; ret_req = 1'b0; reti_req = 1'b0;
        wrs = wr_cnt - w0;
    endtask

    task automatic do_push(input logic [11:0] pc, input logic [7:0] psw, input string tag);
        int lat, wrs;
        run_op(1, 0, 0, pc, psw, 0, lat, wrs);
        chk({tag, " R4 push latency"}, lat, 3);
        chk({tag, " R3 push writes"}, wrs, 2);
        chk({tag, " R2 low byte"}, mem[fr_addr(psw[2:0], 0)], pc[7:0]);
        chk({tag, " R3 high byte"}, mem[fr_addr(psw[2:0], 1)], {psw[7:4], pc[11:8]});
        chk({tag, " R4 psw after push"}, psw_out, exp_push_psw(psw));
        chk({tag, " R4 pc after push"}, pc_out, pc);
    endtask

    task automatic do_pop(input bit interrupt, input logic [7:0] psw, input bit disturb, input string tag);
        int lat, wrs;
        logic [2:0] s;
        logic [7:0] lo, hi;
        s  = psw[2:0] - 3'd1;
        lo = mem[fr_addr(s, 0)];
        hi = mem[fr_addr(s, 1)];
        run_op(0, !interrupt, interrupt, 12'h000, psw, disturb, lat, wrs);
        chk({tag, " R5 pop latency"}, lat, 4);
        chk({tag, " R9 no write on return"}, wrs, 0);
        chk({tag, " R5 restored pc"}, pc_out, {hi[3:0], lo});
        if (interrupt)
            chk({tag, " R6 flags restored"}, psw_out, {hi[7:4], 1'b1, s});
        else
            chk({tag, " R5 flags kept"}, psw_out, {psw[7:4], 1'b1, s});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat, wrs;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 we", ram_we, 0);
        chk("R1 pc", pc_out, 12'h000);
        chk("R1 psw", psw_out, 8'h08);

        // Directed: push at sp0, bit3 cleared on input (R8).
        do_push(12'hA5C, 8'b1010_0000, "d0");
        chk("R8 bit3 forced", psw_out[3], 1);
        // Plain return with different current flags keeps them (R5).
        do_pop(0, 8'b0101_0001, 0, "d1");
        chk("R5 pc value", pc_out, 12'hA5C);
        chk("R5 flags kept value", psw_out, 8'b0101_1000);
        // Interrupt return restores saved flags (R6).
        do_push(12'h3F1, 8'b1100_0010, "d2");
        do_pop(1, 8'b0011_0011, 0, "d3");
        chk("R6 flags value", psw_out, 8'b1100_1010);
        // Wrap: push at sp7 (R7).
        do_push(12'h777, 8'b0001_0111, "d4");
        chk("R7 wrap up ptr", psw_out[2:0], 3'd0);
        chk("R7 wrap hi addr", mem[8'h17], 8'h17);
        // Return at sp0 reads frame 7 (R7).
        do_pop(1, 8'b0000_0000, 0, "d5");
        chk("R7 wrap down pc", pc_out, 12'h777);
        chk("R7 wrap down ptr", psw_out[2:0], 3'd7);
        // Nine pushes overwrite frame 0 (R9).
        for (int k = 0; k < 9; k++)
            do_push(12'(12'h100 + k), {4'h0, 1'b0, 3'(k)}, "d6");
        chk("R9 frame0 overwritten", {mem[8'h09][3:0], mem[8'h08]}, 12'h108);
        // Strobes during a return are ignored (R10).
        do_push(12'h2B4, 8'b0110_0100, "d7");
        do_pop(0, 8'b1001_0101, 1, "d8 R10");
        chk("R10 disturbed pc", pc_out, 12'h2B4);
        chk("R10 disturbed psw", psw_out, 8'b1001_1100);
        // Coincident strobes: push wins (R11).
        run_op(1, 1, 1, 12'h5E6, 8'b1000_0011, 0, lat, wrs);
        chk("R11 push precedence writes", wrs, 2);
        chk("R11 push precedence psw", psw_out, 8'b1000_1100);
        // Return and interrupt return together: interrupt return wins (R11).
        run_op(0, 1, 1, 12'h000, 8'b0000_0100, 0, lat, wrs);
        chk("R11 reti precedence pc", pc_out, 12'h5E6);
        chk("R11 reti precedence psw", psw_out, 8'b1000_1011);

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [7:0] p;
            int kind;
            p = 8'($urandom);
            if ($urandom_range(0, 3) != 0) p[2:0] = psw_out[2:0];
            kind = $urandom_range(0, 2);
            if (kind == 0) do_push(12'($urandom), p, "rnd");
            else           do_pop(kind == 2, p, 0, "rnd");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule